// File: doc/BRIEF.md
# Register-Mapped Serial Port

This block is a byte-wide asynchronous serial port that a 16-bit processor drives through three bus-addressed registers. Writing a byte to the transmit register sends it as a framed serial word on the `tx` line. An independent receiver watches the `rx` line, assembles incoming words and holds the latest byte in a receive register until software reads it. Both directions use a fixed bit period of four system clocks.

A status register tells software whether a received byte is waiting and whether the transmitter is busy. It also carries two sticky flags: one for a received byte that overwrote an unread byte, and one for a transmit write that was refused because a send was already in progress. The interrupt line is high for as long as a received byte is waiting, so bytes that arrive at arbitrary times can be serviced from an interrupt handler. Reading the receive register clears both the waiting flag and the interrupt.

Register offsets (`addr`): 0 = transmit data (write), 1 = receive data (read), 2 = status. Offset 3 and reads of offset 0 return zero.

Top module: `mm_uart`

## Requirements
- R1: A transmitted frame is a low start bit, then the eight data bits least significant bit first, then a high stop bit, and every bit lasts exactly 4 clock cycles.
- R2: A write to offset 0 while the transmitter is idle drives `tx` low from the next cycle on. Status bit 1 (busy) then reads 1 for exactly the 40 cycles that follow the write edge, and `tx` rests high after that.
- R3: A write to offset 0 while status bit 1 is set is discarded and sets status bit 3 (transmit overflow). The frame in flight completes unchanged.
- R4: The receiver accepts frames in the R1 format on `rx`. It then presents the byte in bits 7:0 of offset 1 and sets status bit 0 (byte waiting).
- R5: A read of offset 1 (with `rd_en`) clears status bit 0.
- R6: `irq` is high exactly while status bit 0 is set, and it rises only after a frame completes.
- R7: A frame that completes while status bit 0 is set and no read is clearing it overwrites the receive register and sets status bit 2 (receive overflow).
- R8: Writing a 1 to status bit 2 or bit 3 clears that flag. Writing 0 there leaves the flag unchanged.
- R9: A low pulse on `rx` that has already ended by the middle of the start bit is ignored. No byte is delivered and the receiver stays ready for the next frame.
- R10: A frame whose stop bit is sampled low is dropped. Offset 1 keeps its old byte and status bit 0 is unchanged.
- R11: After reset, `tx` and `irq` are at 1 and 0 respectively, status reads 0 and offset 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| rd_en | input | 1 | Read strobe; side effect on offset 1 |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| tx | output | 1 | Serial transmit line, idle high |
| rx | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Received-byte interrupt, active high |

## Verification
The bench uses the default parameters: four clocks per bit and eight data bits. With these values a full 40-cycle frame stays short, so each transmit bit can be sampled at its exact cycle. The busy window can be checked at the edge where it ends, and a refused write can be placed inside a live frame. The same short frame lets the bench place a start-bit glitch, a low stop bit and two back-to-back received bytes, each at a known cycle offset from the receiver's mid-bit sample.

// File: rtl/mm_uart_pkg.sv
package mm_uart_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned BUS_W  = 16;

  localparam logic [ADDR_W-1:0] OFS_TXD  = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd2;

  localparam int unsigned ST_RXV = 0;
  localparam int unsigned ST_TXB = 1;
  localparam int unsigned ST_RXO = 2;
  localparam int unsigned ST_TXO = 3;

  typedef struct packed {
    logic tx_ovf;
    logic rx_ovf;
    logic tx_busy;
    logic rx_valid;
  } stat_t;

  typedef enum logic {RX_IDLE = 1'b0, RX_FRAME = 1'b1} rx_state_t;
endpackage

// File: rtl/mm_uart_sync.sv
module mm_uart_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = din;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mm_uart_tx.sv
module mm_uart_tx #(
  parameter int unsigned CLKS_PER_BIT = 4,
  parameter int unsigned DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] din,
  output logic                 busy,
  output logic                 txd
);
  localparam int unsigned FRAME = DATA_BITS + 2;
  localparam int unsigned CW    = $clog2(CLKS_PER_BIT);
  localparam int unsigned IW    = $clog2(FRAME);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME - 1);

  logic             busy_q, busy_d;
  logic [FRAME-1:0] sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, din, 1'b0};
        cnt_d  = '0;
        idx_d  = '0;
      end
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[FRAME-1:1]};
      if (idx_q == IDX_LAST) busy_d = 1'b0;
      else                   idx_d  = idx_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign txd  = sh_q[0];
endmodule

// File: rtl/mm_uart_rx.sv
module mm_uart_rx
  import mm_uart_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 4,
  parameter int unsigned DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  output logic                 done,
  output logic [DATA_BITS-1:0] dout
);
  localparam int unsigned FRAME = DATA_BITS + 2;
  localparam int unsigned CW    = $clog2(CLKS_PER_BIT);
  localparam int unsigned IW    = $clog2(FRAME);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(CLKS_PER_BIT / 2);
  localparam logic [IW-1:0] IDX_STOP = IW'(FRAME - 1);

  rx_state_t            st_q, st_d;
  logic                 prev_q;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (st_q == RX_IDLE) begin
      if (prev_q && !rxd) begin
        st_d  = RX_FRAME;
        cnt_d = CW'(1);
        idx_d = '0;
      end
    end else begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == CNT_MID) begin
        if (idx_q == '0) begin
          if (rxd) st_d = RX_IDLE;
          idx_d = idx_q + 1'b1;
        end else if (idx_q == IDX_STOP) begin
          st_d   = RX_IDLE;
          done_d = rxd;
        end else begin
          sh_d  = {rxd, sh_q[DATA_BITS-1:1]};
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      prev_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      prev_q <= rxd;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  assign done = done_d;
  assign dout = sh_q;
endmodule

// File: rtl/mm_uart.sv
module mm_uart
  import mm_uart_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 4,
  parameter int unsigned DATA_BITS    = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              tx,
  input  logic              rx,
  output logic              irq
);
  logic                 rx_s;
  logic                 rx_done;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 tx_busy;
  logic                 tx_start;
  logic                 rd_rx, wr_tx, wr_st;

  logic [DATA_BITS-1:0] rx_data_q, rx_data_d;
  logic                 rx_valid_q, rx_valid_d;
  logic                 rx_ovf_q, rx_ovf_d;
  logic                 tx_ovf_q, tx_ovf_d;
  stat_t                stat;

  mm_uart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx), .dout(rx_s)
  );

  mm_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rx_s), .done(rx_done), .dout(rx_byte)
  );

  mm_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .din(wdata[DATA_BITS-1:0]),
    .busy(tx_busy), .txd(tx)
  );

  assign rd_rx    = rd_en && (addr == OFS_RXD);
  assign wr_tx    = wr_en && (addr == OFS_TXD);
  assign wr_st    = wr_en && (addr == OFS_STAT);
  assign tx_start = wr_tx && !tx_busy;

  always_comb begin
    rx_data_d  = rx_data_q;
    rx_valid_d = rx_valid_q;
    rx_ovf_d   = rx_ovf_q;
    tx_ovf_d   = tx_ovf_q;
    if (rx_done) begin
      rx_data_d  = rx_byte;
      rx_valid_d = 1'b1;
    end else if (rd_rx) begin
      rx_valid_d = 1'b0;
    end
    if (rx_done && rx_valid_q && !rd_rx) rx_ovf_d = 1'b1;
    else if (wr_st && wdata[ST_RXO])     rx_ovf_d = 1'b0;
    if (wr_tx && tx_busy)                tx_ovf_d = 1'b1;
    else if (wr_st && wdata[ST_TXO])     tx_ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      rx_ovf_q   <= 1'b0;
      tx_ovf_q   <= 1'b0;
    end else begin
      rx_data_q  <= rx_data_d;
      rx_valid_q <= rx_valid_d;
      rx_ovf_q   <= rx_ovf_d;
      tx_ovf_q   <= tx_ovf_d;
    end
  end

  assign stat = '{tx_ovf: tx_ovf_q, rx_ovf: rx_ovf_q,
                  tx_busy: tx_busy, rx_valid: rx_valid_q};

  always_comb begin
    case (addr)
      OFS_RXD:  rdata = BUS_W'(rx_data_q);
      OFS_STAT: rdata = BUS_W'(stat);
      default:  rdata = '0;
    endcase
  end

  assign irq = rx_valid_q;
endmodule

// File: rtl/mm_uart_chk.sv
module mm_uart_chk
  import mm_uart_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [BUS_W-1:0]  wdata,
  input logic              tx,
  input logic              irq,
  input logic              tx_busy,
  input logic              rx_done,
  input logic              rx_ovf,
  input logic              tx_ovf
);
  assert_tx_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TXD && !tx_busy) |=> (!tx && tx_busy));

  assert_tx_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TXD && tx_busy) |=> tx_ovf);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_RXD && !rx_done) |=> !irq);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rx_done));

  assert_rx_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ovf) |-> $past(wr_en && addr == OFS_STAT && wdata[ST_RXO]));

  assert_tx_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ovf) |-> $past(wr_en && addr == OFS_STAT && wdata[ST_TXO]));
endmodule

bind mm_uart mm_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .tx(tx), .irq(irq), .tx_busy(tx_busy), .rx_done(rx_done),
  .rx_ovf(rx_ovf_q), .tx_ovf(tx_ovf_q)
);

// File: tb/mm_uart_tb.sv
`timescale 1ns/1ps
module mm_uart_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tx;
  logic        rx = 1'b1;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mm_uart u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .tx(tx), .rx(rx), .irq(irq)
  );

  // upper byte: byte to transmit, lower byte: byte to receive
  localparam logic [15:0] VEC [6] = '{16'hA53C, 16'h0001, 16'h80FF,
                                      16'hFF00, 16'h5AC3, 16'h7E81};

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #0.5 d = rdata;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  // Write a byte and sample the frame at each bit; optionally refuse-write mid frame
  task automatic send_and_capture(input logic [7:0] b, input logic do_ovf,
                                  input logic [7:0] b2, output logic [9:0] fr,
                                  output logic busy39, output logic busy40);
    logic [15:0] st;
    bus_write(2'd0, {8'h00, b});
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      fr[i] = tx;
      if (i < 9) begin
        if (do_ovf && i == 3) begin
          addr = 2'd0; wdata = {8'h00, b2}; wr_en = 1'b1;
          @(negedge clk);
          wr_en = 1'b0;
          repeat (3) @(negedge clk);
        end else begin
          repeat (4) @(negedge clk);
        end
      end
    end
    addr = 2'd2;
    repeat (2) @(negedge clk);
    #0.5 st = rdata;
    busy39 = st[1];
    @(negedge clk);
    #0.5 st = rdata;
    busy40 = st[1];
  endtask

  task automatic drive_rx(input logic [7:0] b, input logic stop_bit);
    logic [9:0] fr;
    fr = {stop_bit, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      rx = fr[i];
      repeat (4) @(negedge clk);
    end
    rx = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [9:0]  fr;
    logic        b39, b40;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    peek(2'd2, d); check("R11 status", d, 16'h0000);
    peek(2'd1, d); check("R11 rx data", d, 16'h0000);
    peek(2'd0, d); check("R11 offset0", d, 16'h0000);
    check("R11 tx idle", tx, 1'b1);
    check("R11 irq", irq, 1'b0);

    // table-driven main function
    for (int v = 0; v < 6; v++) begin
      send_and_capture(VEC[v][15:8], 1'b0, 8'h00, fr, b39, b40);
      check("R1 frame", fr, {1'b1, VEC[v][15:8], 1'b0});
      check("R2 busy last cycle", b39, 1'b1);
      check("R2 idle after 40", b40, 1'b0);
      check("R2 tx rest", tx, 1'b1);
      drive_rx(VEC[v][7:0], 1'b1);
      check("R6 irq set", irq, 1'b1);
      peek(2'd2, d); check("R4 valid", d[0], 1'b1);
      bus_read(2'd1, d); check("R4 rx byte", d, {8'h00, VEC[v][7:0]});
      @(negedge clk);
      check("R5 irq cleared", irq, 1'b0);
      peek(2'd2, d); check("R5 valid cleared", d, 16'h0000);
    end

    // R3 refused write mid-frame
    send_and_capture(8'hC6, 1'b1, 8'h39, fr, b39, b40);
    check("R3 frame unchanged", fr, {1'b1, 8'hC6, 1'b0});
    peek(2'd2, d); check("R3 tx overflow", d, 16'h0008);
    bus_write(2'd2, 16'h0000);
    peek(2'd2, d); check("R8 zero keeps", d, 16'h0008);
    bus_write(2'd2, 16'h0008);
    peek(2'd2, d); check("R8 clear tx ovf", d, 16'h0000);

    // R7 receive overflow
    drive_rx(8'h11, 1'b1);
    drive_rx(8'h22, 1'b1);
    peek(2'd2, d); check("R7 rx overflow", d, 16'h0005);
    peek(2'd1, d); check("R7 overwrite", d, 16'h0022);
    bus_read(2'd1, d);
    bus_write(2'd2, 16'h0004);
    peek(2'd2, d); check("R8 clear rx ovf", d, 16'h0000);

    // R10 bad stop bit
    drive_rx(8'h5A, 1'b0);
    peek(2'd2, d); check("R10 valid unchanged", d, 16'h0000);
    peek(2'd1, d); check("R10 data kept", d, 16'h0022);
    check("R10 irq", irq, 1'b0);

    // R9 start glitch
    @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b1;
    repeat (50) @(negedge clk);
    peek(2'd2, d); check("R9 glitch ignored", d, 16'h0000);
    drive_rx(8'h96, 1'b1);
    peek(2'd1, d); check("R9 recovers", d, 16'h0096);
    check("R6 irq after recovery", irq, 1'b1);

    report();
    $finish;
  end
endmodule